// File: doc/BRIEF.md
# Sixteen-bit capture/compare timer with tick prescaler

This block is a 16-bit up/down counter whose behaviour is set by one 11-bit control word. The counter advances only on ticks. A tick comes either from the system clock divided by a power of two between 1 and 128, or from rising edges of an external event pin. In the two compare modes the counter is matched against a compare operand, and a match either flips the `cmp_out` pin or raises it for one clock. In the capture modes the current count is copied into `cap_val` on edges of the `cap_pin` input. Rising-edge capture can be thinned so that it fires only on every 2nd, 4th or 8th rising edge. Every match and every capture makes a level interrupt pending.

Both external pins pass through a two-flop synchronizer and then an edge detector. This puts three clocks of latency between a pin change and its effect. The interrupt is held by a state machine with three states. IRQ_IDLE goes to IRQ_PEND on an event. IRQ_PEND goes to IRQ_ARMED once the acknowledge bit reads 1. IRQ_ARMED goes back to IRQ_IDLE once the acknowledge bit reads 0 again, or to IRQ_PEND instead if a new event lands in that same cycle. The `irq` output is high in IRQ_PEND and in IRQ_ARMED.

Control word layout: bit 0 run, bits 3:1 mode, bit 4 halt-in-debug, bit 5 acknowledge, bits 9:6 tick select, bit 10 count down.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, `count`, `cap_val`, `cmp_out` and `irq` are all 0, and every control field is treated as 0.
- R2: With run (bit 0) at 0, `count` holds its value, no capture or match occurs, and `irq` stays low.
- R3: Tick select (bits 9:6) codes 0 and 1 tick every clock. Codes 2 to 8 tick once every 2^(code-1) clocks. The divider restarts whenever the timer is not running, so after M running clocks the count has moved by floor(M / 2^(code-1)).
- R4: Tick select codes 9 to 14 produce no ticks, and `count` holds its value.
- R5: Tick select code 15 advances the count once for each synchronized rising edge of `evt_pin`.
- R6: Bit 10 set makes the counter decrement and wrap modulo 2^16; cleared, it increments.
- R7: With halt-in-debug (bit 4) at 1 and `dbg_req` high, `count` holds its value. With bit 4 at 0, `dbg_req` has no effect.
- R8: Mode 001: in the clock edge where a tick makes `count` equal `cmp_val`, `cmp_out` flips.
- R9: Mode 010: `cmp_out` is high for exactly the one clock that follows the tick that makes `count` equal `cmp_val`, and is low otherwise.
- R10: Mode 011 captures `count` on each falling edge of `cap_pin`, and mode 100 on each rising edge. The captured value is the count held two clocks after the pin change.
- R11: Modes 101, 110 and 111 capture on every 2nd, 4th and 8th rising edge. The edge counter restarts whenever the mode field changes.
- R12: Any match or capture sets `irq`. Only a 1 followed by a 0 on the acknowledge bit (bit 5) clears it, and `irq` stays high while that bit is held at 1.
- R13: Mode 000 leaves `cmp_out` and `cap_val` unchanged and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 11 | Control word (layout above) |
| cmp_val | input | 16 | Compare operand |
| dbg_req | input | 1 | Processor debug state indication |
| cap_pin | input | 1 | Asynchronous capture input |
| evt_pin | input | 1 | Asynchronous external tick input |
| count | output | 16 | Current counter value |
| cap_val | output | 16 | Last captured count |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a thinned-capture edge counter that is part-way through its cycle when the mode field changes. If that stale count survived, it would trigger a capture too early. The stimulus sends five rising edges in every-8th mode, switches briefly to normal mode and back, and then sends three more edges. No capture may occur there. A further five edges must then produce exactly one capture. The prescaler sweep and the capture sweeps compute their expected counts and captured values arithmetically, from the clock at which each tick or edge was driven.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTRL_W     = 11;
    localparam int SEL_W      = 4;
    localparam int CF_RUN     = 0;
    localparam int CF_MODE_LO = 1;
    localparam int CF_HALT    = 4;
    localparam int CF_ACK     = 5;
    localparam int CF_SEL_LO  = 6;
    localparam int CF_DOWN    = 10;

    typedef enum logic [2:0] {
        CM_FREE     = 3'b000,
        CM_TOGGLE   = 3'b001,
        CM_PULSE    = 3'b010,
        CM_CAP_FALL = 3'b011,
        CM_CAP_RISE = 3'b100,
        CM_CAP_2ND  = 3'b101,
        CM_CAP_4TH  = 3'b110,
        CM_CAP_8TH  = 3'b111
    } cc_mode_e;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'b00,
        IRQ_PEND  = 2'b01,
        IRQ_ARMED = 2'b10
    } irq_st_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] q,
    output logic [LANES-1:0] q_d
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], din[l]};
        end
        assign q[l]   = sh[STAGES-1];
        assign q_d[l] = sh[STAGES];
    end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV_W = 7,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    input  logic             evt_rise,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [SEL_W-1:0] EXT_CODE = '1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   one_hot;
    logic [DIV_W-1:0] mask;
    logic             div_ok;
    int               k;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) div_cnt <= '0;
        else                   div_cnt <= div_cnt + ONE;
    end

    always_comb begin
        div_ok = 1'b0;
        k      = 0;
        if (int'(sel) <= 1) begin
            div_ok = 1'b1;
        end else if (int'(sel) <= DIV_W + 1) begin
            div_ok = 1'b1;
            k      = int'(sel) - 1;
        end
        one_hot = (DIV_W+1)'(1) << k;
        mask    = one_hot[DIV_W-1:0] - ONE;
        tick    = active && (((sel == EXT_CODE) && evt_rise) ||
                             (div_ok && ((div_cnt & mask) == mask)));
    end
endmodule

// File: rtl/tmr_irq_fsm.sv
module tmr_irq_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic ack_i,
    output logic irq_o
);
    irq_st_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= IRQ_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            IRQ_IDLE:  if (event_i) st_nxt = IRQ_PEND;
            IRQ_PEND:  if (ack_i)   st_nxt = IRQ_ARMED;
            IRQ_ARMED: if (!ack_i)  st_nxt = event_i ? IRQ_PEND : IRQ_IDLE;
            default:                st_nxt = IRQ_IDLE;
        endcase
    end

    always_comb irq_o = (st != IRQ_IDLE);

    // R12: holding the acknowledge bit at 1 never drops the interrupt
    p_ack_high_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> irq_o);
    // R12: the falling half of the sequence clears when no new event arrives
    p_clear_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IRQ_ARMED && !ack_i && !event_i) |=> !irq_o);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [10:0]       ctrl,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic              dbg_req,
    input  logic              cap_pin,
    input  logic              evt_pin,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cmp_out,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             run, halt_en, ack, down;
    logic [SEL_W-1:0] sel;
    cc_mode_e         mode, mode_q;

    assign run     = ctrl[CF_RUN];
    assign mode    = cc_mode_e'(ctrl[CF_MODE_LO +: 3]);
    assign halt_en = ctrl[CF_HALT];
    assign ack     = ctrl[CF_ACK];
    assign sel     = ctrl[CF_SEL_LO +: SEL_W];
    assign down    = ctrl[CF_DOWN];

    logic active, tick, hit, cap_fire, nth_mode;
    logic [1:0] s_q, s_qd;
    logic cap_rise, cap_fall, evt_rise;
    logic [CNT_W-1:0] cnt_nxt;
    logic [2:0] ecnt, elim;

    assign active = run && !(halt_en && dbg_req);

    tmr_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({evt_pin, cap_pin}), .q(s_q), .q_d(s_qd)
    );
    assign cap_rise = s_q[0] & ~s_qd[0];
    assign cap_fall = ~s_q[0] & s_qd[0];
    assign evt_rise = s_q[1] & ~s_qd[1];

    tmr_tick_gen #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .active(active), .sel(sel),
        .evt_rise(evt_rise), .tick(tick)
    );

    assign cnt_nxt = down ? count - CNT_ONE : count + CNT_ONE;
    assign hit     = tick && (cnt_nxt == cmp_val) &&
                     (mode == CM_TOGGLE || mode == CM_PULSE);

    always_comb begin
        nth_mode = 1'b1;
        unique case (mode)
            CM_CAP_2ND: elim = 3'd1;
            CM_CAP_4TH: elim = 3'd3;
            CM_CAP_8TH: elim = 3'd7;
            default: begin elim = 3'd0; nth_mode = 1'b0; end
        endcase
        unique case (mode)
            CM_CAP_FALL: cap_fire = active && cap_fall;
            CM_CAP_RISE: cap_fire = active && cap_rise;
            CM_CAP_2ND, CM_CAP_4TH, CM_CAP_8TH:
                cap_fire = active && cap_rise && (mode == mode_q) && (ecnt == elim);
            default:     cap_fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            cap_val <= '0;
            cmp_out <= 1'b0;
            mode_q  <= CM_FREE;
            ecnt    <= '0;
        end else begin
            mode_q <= mode;
            if (tick) count <= cnt_nxt;
            if (cap_fire) cap_val <= count;
            if (mode != mode_q)
                ecnt <= '0;
            else if (nth_mode && active && cap_rise)
                ecnt <= (ecnt == elim) ? 3'd0 : ecnt + 3'd1;
            unique case (mode)
                CM_TOGGLE: cmp_out <= cmp_out ^ hit;
                CM_PULSE:  cmp_out <= hit;
                default:   cmp_out <= cmp_out;
            endcase
        end
    end

    tmr_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n), .event_i(hit | cap_fire), .ack_i(ack), .irq_o(irq)
    );

    // R2: a stopped timer keeps its count
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));
    // R4: reserved tick codes never advance the count
    p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= 9 && int'(sel) <= 14) |=> $stable(count));
    // R7: debug halt freezes the count
    p_debug_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_en && dbg_req) |=> $stable(count));
    // R8: toggle output only moves when the count reached the operand
    p_toggle_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == CM_TOGGLE && !$stable(cmp_out)) |-> (count == $past(cmp_val)));
    // R9: pulse output high only right after reaching the operand
    p_pulse_on_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == CM_PULSE && cmp_out) |-> (count == $past(cmp_val)));
endmodule

// File: tb/sim_capcmp_timer.sv
`timescale 1ns/1ps
module sim_capcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl = '0;
    logic [15:0] cmp_val = '0;
    logic        dbg_req = 1'b0, cap_pin = 1'b0, evt_pin = 1'b0;
    wire  [15:0] count, cap_val;
    wire         cmp_out, irq;

    int n_chk = 0, n_fail = 0;
    int cap_chg = 0;
    logic [15:0] cap_prev = '0;

    always #2 clk = ~clk;

    capcmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cmp_val(cmp_val), .dbg_req(dbg_req),
        .cap_pin(cap_pin), .evt_pin(evt_pin), .count(count), .cap_val(cap_val),
        .cmp_out(cmp_out), .irq(irq)
    );

    function automatic logic [10:0] cw(input bit run, input logic [2:0] md, input bit halt,
                                       input bit ack, input logic [3:0] sel, input bit down);
        return {down, sel, ack, halt, md, run};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            @(negedge clk);
            if (cap_val !== cap_prev) begin cap_chg++; cap_prev = cap_val; end
        end
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cap_pin = 1'b1; tick_n(2);
            cap_pin = 1'b0; tick_n(2);
        end
    endtask

    task automatic irq_clear();
        ctrl = cw(0, 3'd0, 0, 1, 4'd1, 0); tick_n(2);
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(2);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] start, exp16;
        bit c0;
        int k;
        repeat (3) @(negedge clk);
        chk(count == 0 && cap_val == 0, "R1 count/cap", int'(count) + int'(cap_val), 0);
        chk(cmp_out == 0 && irq == 0, "R1 cmp_out/irq", int'(cmp_out) + int'(irq), 0);
        rst_n = 1'b1;

        // R2: stopped timer, capture mode, pin activity
        ctrl = cw(0, 3'd4, 0, 0, 4'd1, 0);
        cap_prev = cap_val; cap_chg = 0;
        pin_pulses(4); tick_n(4);
        chk(count == 0, "R2 count held", count, 0);
        chk(cap_chg == 0 && irq == 0, "R2 no events", cap_chg + int'(irq), 0);

        // R3: prescaler sweep
        for (int code = 0; code <= 8; code++) begin
            start = count;
            ctrl = cw(1, 3'd0, 0, 0, 4'(code), 0);
            tick_n(256);
            k = (code <= 1) ? 0 : code - 1;
            exp16 = start + 16'(256 >> k);
            chk(count == exp16, $sformatf("R3 code %0d", code), count, exp16);
            ctrl = cw(0, 3'd0, 0, 0, 4'(code), 0); tick_n(1);
        end

        // R4: reserved codes
        for (int code = 9; code <= 14; code++) begin
            start = count;
            ctrl = cw(1, 3'd0, 0, 0, 4'(code), 0);
            tick_n(40);
            chk(count == start, $sformatf("R4 code %0d", code), count, start);
        end

        // R6: count down with wrap
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(1);
        start = count;
        ctrl = cw(1, 3'd0, 0, 0, 4'd1, 1); tick_n(700);
        exp16 = start - 16'd700;
        chk(count == exp16, "R6 down", count, exp16);

        // R7: debug halt and debug ignored
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(1);
        start = count; dbg_req = 1'b1;
        ctrl = cw(1, 3'd0, 1, 0, 4'd1, 0); tick_n(30);
        chk(count == start, "R7 halted", count, start);
        ctrl = cw(1, 3'd0, 0, 0, 4'd1, 0); tick_n(30);
        exp16 = start + 16'd30;
        chk(count == exp16, "R7 debug ignored", count, exp16);
        dbg_req = 1'b0;

        // R5: external event ticks
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(1);
        start = count;
        ctrl = cw(1, 3'd0, 0, 0, 4'd15, 0);
        for (int i = 0; i < 6; i++) begin
            evt_pin = 1'b1; tick_n(2); evt_pin = 1'b0; tick_n(3);
        end
        tick_n(4);
        exp16 = start + 16'd6;
        chk(count == exp16, "R5 events", count, exp16);

        // R8: toggle twice
        for (int pass = 0; pass < 2; pass++) begin
            ctrl = cw(0, 3'd1, 0, 0, 4'd1, 0); tick_n(1);
            c0 = cmp_out; start = count;
            cmp_val = start + 16'd5;
            ctrl = cw(1, 3'd1, 0, 0, 4'd1, 0);
            tick_n(4);
            chk(cmp_out == c0, "R8 before match", cmp_out, c0);
            tick_n(1);
            chk(cmp_out == !c0, "R8 toggled", cmp_out, !c0);
            chk(irq == 1, "R12 set by match", irq, 1);
            // R12: 1 held keeps irq, then 0 clears
            ctrl = cw(0, 3'd1, 0, 1, 4'd1, 0); tick_n(3);
            chk(irq == 1, "R12 ack high holds", irq, 1);
            ctrl = cw(0, 3'd1, 0, 0, 4'd1, 0); tick_n(1);
            chk(irq == 0, "R12 cleared", irq, 0);
        end

        // R9: one-cycle pulse
        start = count; cmp_val = start + 16'd5;
        ctrl = cw(1, 3'd2, 0, 0, 4'd1, 0);
        tick_n(4);
        chk(cmp_out == 0, "R9 before", cmp_out, 0);
        tick_n(1);
        chk(cmp_out == 1, "R9 pulse", cmp_out, 1);
        tick_n(1);
        chk(cmp_out == 0, "R9 one cycle", cmp_out, 0);
        tick_n(20);
        chk(cmp_out == 0, "R9 stays low", cmp_out, 0);
        chk(irq == 1, "R12 still pending with ack 0", irq, 1);
        irq_clear();

        // R13: normal mode ignores match and pin
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(1);
        c0 = cmp_out; start = count; cmp_val = start + 16'd3;
        cap_prev = cap_val; cap_chg = 0;
        ctrl = cw(1, 3'd0, 0, 0, 4'd1, 0);
        pin_pulses(2); tick_n(4);
        chk(cmp_out == c0 && cap_chg == 0, "R13 outputs unchanged", cap_chg, 0);
        chk(irq == 0, "R13 no irq", irq, 0);

        // R10/R11: rising and every-Nth capture sweeps
        for (int md = 4; md <= 7; md++) begin
            int nn;
            nn = 1 << (md - 4);
            ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(3);
            irq_clear();
            cap_prev = cap_val; cap_chg = 0;
            start = count;
            ctrl = cw(1, 3'(md), 0, 0, 4'd1, 0);
            pin_pulses(8); tick_n(6);
            exp16 = start + 16'd30;
            chk(cap_chg == 8 / nn, $sformatf("R11 mode %0d captures", md), cap_chg, 8 / nn);
            chk(cap_val == exp16, $sformatf("R10 mode %0d value", md), cap_val, exp16);
            chk(irq == 1, "R12 set by capture", irq, 1);
        end

        // R10: falling edge capture
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(3);
        cap_prev = cap_val; cap_chg = 0; start = count;
        ctrl = cw(1, 3'd3, 0, 0, 4'd1, 0);
        pin_pulses(8); tick_n(6);
        exp16 = start + 16'd32;
        chk(cap_chg == 8, "R10 fall captures", cap_chg, 8);
        chk(cap_val == exp16, "R10 fall value", cap_val, exp16);

        // R11: mode change restarts the edge counter
        ctrl = cw(0, 3'd0, 0, 0, 4'd1, 0); tick_n(3);
        ctrl = cw(1, 3'd7, 0, 0, 4'd1, 0);
        pin_pulses(5);
        ctrl = cw(1, 3'd0, 0, 0, 4'd1, 0); tick_n(2);
        ctrl = cw(1, 3'd7, 0, 0, 4'd1, 0); tick_n(2);
        cap_prev = cap_val; cap_chg = 0;
        pin_pulses(3); tick_n(6);
        chk(cap_chg == 0, "R11 restart no early capture", cap_chg, 0);
        pin_pulses(5); tick_n(6);
        chk(cap_chg == 1, "R11 capture on 8th after restart", cap_chg, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule